// File: doc/BRIEF.md
# Cascaded Carry Tone Generator

This block produces a single 1-bit square or pulse waveform for beeper-style music. A first 8-bit phase register adds a pitch word on every sample tick and wraps modulo 256. The carry from that addition is the raw top-octave pulse train. Each time the first register carries, a second 8-bit register adds a scaling value. The carry out of that second addition, held in a flip-flop, is the audible bit. Neither stage has a reload counter or a compare.

The pitch word sets the tone within the top octave, where words 0x80 to 0xFF are the intended band. The scaling value then sets the octave, the loudness and the timbre. A scaling value of 128 halves the carry rate and 64 quarters it, so octaves stay exactly aligned. A scaling value slightly off a power of two gives irregular, thinning pulse trains, which are useful for fades. A harmonic mask is ANDed into the scaling value, so one channel can change its harmonic content. The pitch, scaling value and mask may change between ticks without losing the accumulated phase.

Top module: `carry_cascade_tone`

## Requirements
- R1: After reset, both accumulators and `audio_out` are zero. With pitch 0x80, scale 0x80 and mask 0xFF, ticks 1 to 4 after reset give `audio_out` = 0, 0, 0, 1.
- R2: On every tick, the first accumulator adds `pitch_word` modulo 256. It carries exactly when the sum reaches 256 or more.
- R3: The second accumulator advances only on ticks where the first stage carries. On such a tick it adds `scale_val & harm_mask` modulo 256.
- R4: On each tick, `audio_out` is loaded with the carry of the second-stage addition on that tick. It holds its value between ticks.
- R5: When `tick` is low, changes on `pitch_word`, `scale_val` and `harm_mask` have no effect: `audio_out` does not change, and later ticks continue from the unchanged phase.
- R6: With scale 128 and mask 0xFF, starting from reset, the number of ticks with `audio_out` high over 256·k ticks equals pitch·k/2 within ±1. With scale 64, the count is pitch·k/4 within ±1.
- R7: A new pitch or scaling value takes effect on the next tick and leaves the accumulated phase of both stages intact.
- R8: The harmonic mask is ANDed bitwise with the scaling value. With scale 0xFF and mask 0x80, the output equals the output with scale 0x80 and mask 0xFF.
- R9: Scale 134 (128 plus 6) with pitch 0xFF gives at least two distinct intervals between successive output pulses.
- R10: A pitch of 0, or a scale & mask of 0, keeps `audio_out` low on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick | input | 1 | Sample-tick enable; both stages advance only when high |
| pitch_word | input | 8 | Pitch increment for the first accumulator |
| scale_val | input | 8 | Increment for the second accumulator, applied per first-stage carry |
| harm_mask | input | 8 | Bitwise mask applied to `scale_val` |
| audio_out | output | 1 | Registered 1-bit audio output |

## Verification
A corrupted phase in either accumulator has no visible effect until a carry moves. A wrong first-stage value shows up as a pulse that appears or vanishes within at most 256 ticks. A wrong second-stage value shifts the pulse position within a few first-stage carries. The bench runs a tick-by-tick reference model against the output, so any such divergence is flagged on the first tick where the output differs. Over whole 256-tick windows it also compares pulse counts, which exposes rate errors that cancel locally.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned ACC_W = 8;
  localparam int unsigned SUM_W = ACC_W + 1;
  typedef logic [ACC_W-1:0] acc_t;
endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc #(
  parameter int unsigned W = tone_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] step,
  output logic         carry
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  phase_q;
  logic [W-1:0]  phase_d;
  logic [SW-1:0] sum;

  always_comb begin
    sum     = {1'b0, phase_q} + {1'b0, step};
    phase_d = sum[W-1:0];
    carry   = tick & sum[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= phase_d;
    end
  end

  // R5
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase_q));

  // R2
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && carry) |=> (phase_q < $past(step)));

  // R2
  phase_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !carry) |=> (phase_q >= $past(step)));
endmodule

// File: rtl/tone_scale_gate.sv
module tone_scale_gate #(
  parameter int unsigned W = tone_pkg::ACC_W
) (
  input  logic [W-1:0] scale,
  input  logic [W-1:0] mask,
  input  logic         carry_in,
  output logic [W-1:0] addend
);
  logic [W-1:0] shaped;

  always_comb begin
    shaped = scale & mask;
    addend = {W{carry_in}} & shaped;
  end
endmodule

// File: rtl/tone_scale_acc.sv
module tone_scale_acc #(
  parameter int unsigned W = tone_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] addend,
  output logic         bit_out
);
  localparam int unsigned SW = W + 1;

  logic [W-1:0]  level_q;
  logic [W-1:0]  level_d;
  logic [SW-1:0] sum;
  logic          out_d;

  always_comb begin
    sum     = {1'b0, level_q} + {1'b0, addend};
    level_d = sum[W-1:0];
    out_d   = sum[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      bit_out <= 1'b0;
    end else if (tick) begin
      level_q <= level_d;
      bit_out <= out_d;
    end
  end

  // R3
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && (addend != '0)) |=> $stable(level_q));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bit_out));

  // R10
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (addend == '0)) |=> !bit_out);
endmodule

// File: rtl/carry_cascade_tone.sv
module carry_cascade_tone #(
  parameter int unsigned W = tone_pkg::ACC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] pitch_word,
  input  logic [W-1:0] scale_val,
  input  logic [W-1:0] harm_mask,
  output logic         audio_out
);
  logic         top_carry;
  logic [W-1:0] scale_add;

  tone_phase_acc #(.W(W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .step  (pitch_word),
    .carry (top_carry)
  );

  tone_scale_gate #(.W(W)) u_gate (
    .scale    (scale_val),
    .mask     (harm_mask),
    .carry_in (top_carry),
    .addend   (scale_add)
  );

  tone_scale_acc #(.W(W)) u_scale (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .addend  (scale_add),
    .bit_out (audio_out)
  );

  // R3
  no_carry_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !top_carry) |=> !audio_out);
endmodule

// File: tb/carry_cascade_tone_test.sv
module carry_cascade_tone_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] pitch_word = 8'h00;
  logic [7:0] scale_val = 8'h00;
  logic [7:0] harm_mask = 8'hFF;
  logic       audio_out;

  int total = 0;
  int bad = 0;
  int pulse_cnt = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic  v;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int m1 = 0;
  int m2 = 0;

  always #4 clk = ~clk;

  carry_cascade_tone uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .pitch_word (pitch_word),
    .scale_val  (scale_val),
    .harm_mask  (harm_mask),
    .audio_out  (audio_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one expected item per tick edge
  always begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(audio_out === e.v, e.req, int'(audio_out), int'(e.v));
      if (audio_out === 1'b1) pulse_cnt++;
    end
  end

  // Driver: one tick with a reference-model prediction
  task automatic drive_tick(input logic [7:0] p, input logic [7:0] s,
                            input logic [7:0] m, input string req);
    exp_t e;
    int c1;
    int add;
    @(negedge clk);
    pitch_word = p;
    scale_val  = s;
    harm_mask  = m;
    tick       = 1'b1;
    m1 = m1 + p;
    c1 = (m1 >= 256) ? 1 : 0;
    m1 = m1 % 256;
    add = c1 ? (s & m) : 0;
    m2 = m2 + add;
    e.v = (m2 >= 256) ? 1'b1 : 1'b0;
    m2 = m2 % 256;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    tick = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    tick  = 1'b0;
    rst_n = 1'b0;
    m1 = 0;
    m2 = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_count(input logic [7:0] p, input logic [7:0] s,
                           input logic [7:0] m, input int k, input int expv,
                           input string req);
    do_reset();
    pulse_cnt = 0;
    for (int i = 0; i < 256 * k; i++) drive_tick(p, s, m, req);
    idle(2);
    check((pulse_cnt >= expv - 1) && (pulse_cnt <= expv + 1), req, pulse_cnt, expv);
  endtask

  initial begin : watchdog
    while (!done && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic held;
    int last_t;
    int min_gap;
    int max_gap;
    int t;
    exp_t e;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(audio_out === 1'b0, "R1", int'(audio_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(audio_out === 1'b0, "R1", int'(audio_out), 0);

    // R1 / R2 / R3 / R4: sequence from reset (0,0,0,1)
    for (int i = 0; i < 16; i++) drive_tick(8'h80, 8'h80, 8'hFF, "R1");
    idle(2);

    // R2 / R3: varied pitches and scales
    for (int i = 0; i < 300; i++) drive_tick(8'hB3, 8'h55, 8'hFF, "R2");
    for (int i = 0; i < 300; i++) drive_tick(8'hF1, 8'hC8, 8'hFF, "R3");
    idle(2);

    // R5: inputs change without tick; output must hold
    held = audio_out;
    pitch_word = 8'hFF;
    scale_val  = 8'hFF;
    harm_mask  = 8'hFF;
    repeat (20) @(negedge clk);
    check(audio_out === held, "R5", int'(audio_out), int'(held));
    // later ticks continue from unchanged phase (model untouched)
    for (int i = 0; i < 100; i++) drive_tick(8'hF1, 8'hC8, 8'hFF, "R5");
    idle(2);

    // R7: change pitch and scale on the fly, no phase clear
    for (int i = 0; i < 50; i++) drive_tick(8'h9A, 8'h40, 8'hFF, "R7");
    for (int i = 0; i < 50; i++) drive_tick(8'hE0, 8'h81, 8'hFF, "R7");
    for (int i = 0; i < 50; i++) drive_tick(8'h83, 8'h20, 8'hFF, "R7");
    idle(2);

    // R8: mask ANDed into scale
    for (int i = 0; i < 200; i++) drive_tick(8'hC4, 8'hFF, 8'h80, "R8");
    for (int i = 0; i < 200; i++) drive_tick(8'hC4, 8'hF3, 8'h3C, "R8");
    idle(2);

    // R10: silent cases
    pulse_cnt = 0;
    for (int i = 0; i < 300; i++) drive_tick(8'h00, 8'hFF, 8'hFF, "R10");
    for (int i = 0; i < 300; i++) drive_tick(8'hFF, 8'hF0, 8'h0F, "R10");
    idle(2);
    check(pulse_cnt == 0, "R10", pulse_cnt, 0);

    // R6: octave-exact counts
    run_count(8'h90, 8'h80, 8'hFF, 4, 144 * 4 / 2, "R6");
    run_count(8'h90, 8'h40, 8'hFF, 4, 144 * 4 / 4, "R6");
    run_count(8'hD7, 8'h80, 8'hFF, 2, 215 * 2 / 2, "R6");
    // R8: masked 0xFF/0x80 behaves as scale 128
    run_count(8'h90, 8'hFF, 8'h80, 4, 144 * 4 / 2, "R8");

    // R9: slightly offset scale gives irregular pulse spacing
    do_reset();
    last_t  = -1;
    min_gap = 1000000;
    max_gap = 0;
    for (int i = 0; i < 256; i++) begin
      drive_tick(8'hFF, 8'd134, 8'hFF, "R9");
      @(posedge clk);
      #2;
      t = i;
      if (audio_out === 1'b1) begin
        if (last_t >= 0) begin
          if (t - last_t < min_gap) min_gap = t - last_t;
          if (t - last_t > max_gap) max_gap = t - last_t;
        end
        last_t = t;
      end
    end
    idle(2);
    check(max_gap > min_gap, "R9", max_gap, min_gap + 1);

    // drain check
    check(exp_q.size() == 0, "R4", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule